// File: doc/BRIEF.md
# Dual-Channel Indexed Configuration Register Bank

This block holds the control settings of a converter with a parameterised number of channels (two by default). A byte-wide port carries address, write data and a write enable. The port is assumed to be driven by a serial front end that has already been decoded. The read data always reflects the currently addressed register, combinationally. Some registers are global, and one register exists once per channel. A channel-select register decides which channel copies take a write to the per-channel register.

Writes to the clock and power registers land in a master copy. The decoded control outputs are driven from a slave copy. Masters move to slaves only when a transfer command is written, so several settings can be staged and then applied together in one clock. The port-configuration byte stores its bit-order and soft-reset flags twice, in mirrored bit positions, so the byte means the same thing whichever bit order it was shifted in. A soft reset returns the whole bank to its power-on state. An identity byte and a speed-grade field are read-only constants.

Top module: `dual_chan_cfg_bank`

## Requirements
- R1: After reset the reads return these values: address 0x00 reads 0x18, 0x05 reads all channel bits set (0x03 for two channels), 0x08 reads 0x00, 0x09 reads 0x01 and 0xFF reads 0x00. The outputs show clock stabilizer on, power mode 00, pin function 0 and bit order MSB-first.
- R2: A write to 0x00 sets the LSB-first flag to bit 6 OR bit 1 of the data. The flag is visible on `lsb_first` from the next cycle. Address 0x00 reads back as {0, L, S, 1, 1, S, L, 0}, where L is the LSB-first flag and S is the soft-reset flag.
- R3: A write to 0x00 with bit 5 or bit 2 set makes S read as 1 for one cycle. At the following clock edge every register, master and slave, returns to its R1 value. A write made in that same cycle is lost.
- R4: Address 0x01 always reads the identity byte 0x88, and writes to it change nothing.
- R5: Address 0x02 is read-only and returns the 3-bit speed-grade code in bits [6:4], with all other bits 0. The code is 100 for the lower grade and 101 for the higher grade, which is the default.
- R6: Address 0x05 stores data bits [NCH-1:0] as the channel-select mask, and its upper bits read 0. Bit 0 selects channel A and bit 1 selects channel B.
- R7: A write to the per-channel register 0x08 updates the master copy only of the channels whose mask bit is set. Writes to global registers do not depend on the mask.
- R8: A read of 0x08 returns the master copy of the lowest-numbered channel enabled in the mask. It returns 0x00 when the mask is zero.
- R9: Writes to 0x08 and 0x09 do not change `clk_stab_en`, `pwr_mode` or `pdn_pin_standby` until a transfer takes place.
- R10: A write of 0xFF with bit 0 set makes 0xFF read 0x01 for one cycle. At the next edge all masters are copied to their slaves in a single update, and 0xFF returns to reading 0x00. A write to 0xFF with bit 0 clear does nothing.
- R11: Register 0x08 keeps only bits [1:0] and bit 5, and its other bits read 0. Per channel c, bits [1:0] drive `pwr_mode[2c+1:2c]` (00 normal, 01 full power-down, 10 standby, 11 digital reset). Bit 5 drives `pdn_pin_standby[c]` (0 means power-down, 1 means standby).
- R12: Register 0x09 keeps only bit 0, the clock duty-cycle stabilizer enable, and its other bits read 0.
- R13: Any address other than 0x00, 0x01, 0x02, 0x05, 0x08, 0x09 and 0xFF reads 0x00, and writes to it have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| wr_en | input | 1 | Write strobe for the addressed register |
| addr | input | 8 | Register address |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Read data of the addressed register (combinational) |
| lsb_first | output | 1 | Serial bit order flag |
| clk_stab_en | output | 1 | Active duty-cycle stabilizer enable |
| pwr_mode | output | 2*NCH | Active power mode, two bits per channel |
| pdn_pin_standby | output | NCH | Active external pin function per channel |

## Verification
The per-channel register is written under every mask value: single channel A, single channel B, both channels and none. This separates correct gating from writes that leak across channels. It also shows that readback follows the lowest enabled channel and not a fixed one. Writes to the staged registers are checked with and without a following transfer, and with a write landing in the same cycle as the copy. This exposes slaves that track masters early and copies that take the newer value. Port-configuration writes set only one of each pair of mirrored bits, so the OR decoding and the mirrored readback are each checked from both bit positions. A soft reset is issued from a state where every register differs from its default. Writes to the read-only and unmapped addresses are each followed by a readback.

// File: rtl/dcfg_pkg.sv
package dcfg_pkg;
   localparam logic [7:0] ADR_PORTCFG = 8'h00;
   localparam logic [7:0] ADR_IDENT   = 8'h01;
   localparam logic [7:0] ADR_GRADE   = 8'h02;
   localparam logic [7:0] ADR_CHSEL   = 8'h05;
   localparam logic [7:0] ADR_PWR     = 8'h08;
   localparam logic [7:0] ADR_CLK     = 8'h09;
   localparam logic [7:0] ADR_XFER    = 8'hFF;

   // packed width of the per-channel power field: {pin function, mode[1:0]}
   localparam int PWR_W = 3;
   localparam logic [PWR_W-1:0] PWR_RST = 3'b000;
   localparam logic             CLK_RST = 1'b1;

   function automatic logic [7:0] pcfg_byte(input logic lsb, input logic srst);
      return {1'b0, lsb, srst, 2'b11, srst, lsb, 1'b0};
   endfunction

   function automatic logic [7:0] pwr_unpack(input logic [PWR_W-1:0] p);
      return {2'b00, p[2], 3'b000, p[1:0]};
   endfunction
endpackage

// File: rtl/dcfg_msreg.sv
module dcfg_msreg #(
   parameter int            W   = 1,
   parameter logic [W-1:0]  RST = '0
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         restore,
   input  logic         wr_en,
   input  logic [W-1:0] din,
   input  logic         copy,
   output logic [W-1:0] master,
   output logic [W-1:0] slave
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         master <= RST;
         slave  <= RST;
      end else if (restore) begin
         master <= RST;
         slave  <= RST;
      end else begin
         if (copy)  slave  <= master;
         if (wr_en) master <= din;
      end
   end
endmodule

// File: rtl/dcfg_ctrl.sv
module dcfg_ctrl
   import dcfg_pkg::*;
#(
   parameter int NCH = 2
) (
   input  logic           clk,
   input  logic           rst_n,
   input  logic           wr_en,
   input  logic [7:0]     addr,
   input  logic [7:0]     wdata,
   output logic           lsb_first,
   output logic           srst_pend,
   output logic           xfer_pend,
   output logic [NCH-1:0] chsel
);
   logic wr_pcfg, wr_sel, wr_xfer;

   assign wr_pcfg = wr_en && (addr == ADR_PORTCFG);
   assign wr_sel  = wr_en && (addr == ADR_CHSEL);
   assign wr_xfer = wr_en && (addr == ADR_XFER);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         lsb_first <= 1'b0;
         srst_pend <= 1'b0;
         xfer_pend <= 1'b0;
         chsel     <= '1;
      end else if (srst_pend) begin
         lsb_first <= 1'b0;
         srst_pend <= 1'b0;
         xfer_pend <= 1'b0;
         chsel     <= '1;
      end else begin
         if (wr_pcfg) begin
            lsb_first <= wdata[6] | wdata[1];
            srst_pend <= wdata[5] | wdata[2];
         end
         if (wr_sel) chsel <= wdata[NCH-1:0];
         xfer_pend <= wr_xfer && wdata[0];
      end
   end
endmodule

// File: rtl/dcfg_rdmux.sv
module dcfg_rdmux
   import dcfg_pkg::*;
#(
   parameter int         NCH        = 2,
   parameter logic [7:0] CHIP_ID    = 8'h88,
   parameter logic [2:0] SPEED_CODE = 3'b101
) (
   input  logic [7:0]           addr,
   input  logic                 lsb_first,
   input  logic                 srst_pend,
   input  logic                 xfer_pend,
   input  logic [NCH-1:0]       chsel,
   input  logic [NCH*PWR_W-1:0] pwr_master,
   input  logic                 clk_master,
   output logic [7:0]           rdata
);
   logic [PWR_W-1:0] loc_sel;

   always_comb begin
      loc_sel = '0;
      for (int i = NCH - 1; i >= 0; i--) begin
         if (chsel[i]) loc_sel = pwr_master[i*PWR_W +: PWR_W];
      end
   end

   always_comb begin
      unique case (addr)
         ADR_PORTCFG: rdata = pcfg_byte(lsb_first, srst_pend);
         ADR_IDENT:   rdata = CHIP_ID;
         ADR_GRADE:   rdata = {1'b0, SPEED_CODE, 4'b0000};
         ADR_CHSEL:   rdata = 8'(chsel);
         ADR_PWR:     rdata = pwr_unpack(loc_sel);
         ADR_CLK:     rdata = {7'b0, clk_master};
         ADR_XFER:    rdata = {7'b0, xfer_pend};
         default:     rdata = 8'h00;
      endcase
   end
endmodule

// File: rtl/dual_chan_cfg_bank.sv
module dual_chan_cfg_bank
   import dcfg_pkg::*;
#(
   parameter int         NCH        = 2,
   parameter logic [7:0] CHIP_ID    = 8'h88,
   parameter logic [2:0] SPEED_CODE = 3'b101
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             wr_en,
   input  logic [7:0]       addr,
   input  logic [7:0]       wdata,
   output logic [7:0]       rdata,
   output logic             lsb_first,
   output logic             clk_stab_en,
   output logic [2*NCH-1:0] pwr_mode,
   output logic [NCH-1:0]   pdn_pin_standby
);
   localparam int PWR_BITS = NCH * PWR_W;

   if ((NCH < 1) || (NCH > 8)) begin : g_bad_nch
      $error("dual_chan_cfg_bank: NCH must lie in 1..8");
   end
   if ((SPEED_CODE != 3'b100) && (SPEED_CODE != 3'b101)) begin : g_bad_grade
      $error("dual_chan_cfg_bank: SPEED_CODE must be 3'b100 or 3'b101");
   end

   logic                srst_pend;
   logic                xfer_pend;
   logic [NCH-1:0]      chsel;
   logic [PWR_BITS-1:0] pwr_m;
   logic [PWR_BITS-1:0] pwr_s;
   logic                clk_m;
   logic                wr_pwr;
   logic                wr_clk;

   assign wr_pwr = wr_en && (addr == ADR_PWR);
   assign wr_clk = wr_en && (addr == ADR_CLK);

   dcfg_ctrl #(.NCH(NCH)) i_ctrl (
      .clk       (clk),
      .rst_n     (rst_n),
      .wr_en     (wr_en),
      .addr      (addr),
      .wdata     (wdata),
      .lsb_first (lsb_first),
      .srst_pend (srst_pend),
      .xfer_pend (xfer_pend),
      .chsel     (chsel)
   );

   dcfg_msreg #(.W(1), .RST(CLK_RST)) i_clkreg (
      .clk     (clk),
      .rst_n   (rst_n),
      .restore (srst_pend),
      .wr_en   (wr_clk),
      .din     (wdata[0]),
      .copy    (xfer_pend),
      .master  (clk_m),
      .slave   (clk_stab_en)
   );

   for (genvar c = 0; c < NCH; c++) begin : g_ch
      dcfg_msreg #(.W(PWR_W), .RST(PWR_RST)) i_pwrreg (
         .clk     (clk),
         .rst_n   (rst_n),
         .restore (srst_pend),
         .wr_en   (wr_pwr && chsel[c]),
         .din     ({wdata[5], wdata[1:0]}),
         .copy    (xfer_pend),
         .master  (pwr_m[c*PWR_W +: PWR_W]),
         .slave   (pwr_s[c*PWR_W +: PWR_W])
      );
      assign pwr_mode[c*2 +: 2]  = pwr_s[c*PWR_W +: 2];
      assign pdn_pin_standby[c]  = pwr_s[c*PWR_W + 2];
   end

   dcfg_rdmux #(.NCH(NCH), .CHIP_ID(CHIP_ID), .SPEED_CODE(SPEED_CODE)) i_rdmux (
      .addr       (addr),
      .lsb_first  (lsb_first),
      .srst_pend  (srst_pend),
      .xfer_pend  (xfer_pend),
      .chsel      (chsel),
      .pwr_master (pwr_m),
      .clk_master (clk_m),
      .rdata      (rdata)
   );
endmodule

// File: rtl/dcfg_checker.sv
module dcfg_checker #(
   parameter int         NCH     = 2,
   parameter logic [7:0] CHIP_ID = 8'h88
) (
   input logic             clk,
   input logic             rst_n,
   input logic [7:0]       addr,
   input logic [7:0]       rdata,
   input logic             lsb_first,
   input logic             clk_stab_en,
   input logic [2*NCH-1:0] pwr_mode,
   input logic [NCH-1:0]   pdn_pin_standby,
   input logic             wr_en,
   input logic [7:0]       wdata,
   input logic             srst_pend,
   input logic             xfer_pend
);
   logic unmapped;
   assign unmapped = !(addr inside {8'h00, 8'h01, 8'h02, 8'h05, 8'h08, 8'h09, 8'hFF});

   AST_IDENT_FIXED: assert property (@(posedge clk) disable iff (!rst_n)
      (addr == 8'h01) |-> (rdata == CHIP_ID)); // R4

   AST_UNMAPPED_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
      unmapped |-> (rdata == 8'h00)); // R13

   AST_PCFG_MIRROR: assert property (@(posedge clk) disable iff (!rst_n)
      (addr == 8'h00) |-> (rdata[6] == rdata[1] && rdata[5] == rdata[2] &&
                           rdata[4:3] == 2'b11 && rdata[7] == 1'b0 && rdata[0] == 1'b0)); // R2

   AST_SLAVE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      (!xfer_pend && !srst_pend) |=> ($stable(clk_stab_en) && $stable(pwr_mode) &&
                                      $stable(pdn_pin_standby))); // R9

   AST_XFER_SELF_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
      (xfer_pend && !(wr_en && addr == 8'hFF && wdata[0])) |=> !xfer_pend); // R10

   AST_SRST_RESTORE: assert property (@(posedge clk) disable iff (!rst_n)
      srst_pend |=> (clk_stab_en && pwr_mode == '0 && pdn_pin_standby == '0 &&
                     !lsb_first && !srst_pend)); // R3
endmodule

bind dual_chan_cfg_bank dcfg_checker #(.NCH(NCH), .CHIP_ID(CHIP_ID)) i_dcfg_checker (
   .clk             (clk),
   .rst_n           (rst_n),
   .addr            (addr),
   .rdata           (rdata),
   .lsb_first       (lsb_first),
   .clk_stab_en     (clk_stab_en),
   .pwr_mode        (pwr_mode),
   .pdn_pin_standby (pdn_pin_standby),
   .wr_en           (wr_en),
   .wdata           (wdata),
   .srst_pend       (srst_pend),
   .xfer_pend       (xfer_pend)
);

// File: tb/test_dual_chan_cfg_bank.sv
module test_dual_chan_cfg_bank;
   localparam int NCH = 2;

   logic             clk = 1'b0;
   logic             rst_n = 1'b0;
   logic             wr_en = 1'b0;
   logic [7:0]       addr = 8'h00;
   logic [7:0]       wdata = 8'h00;
   logic [7:0]       rdata;
   logic             lsb_first;
   logic             clk_stab_en;
   logic [2*NCH-1:0] pwr_mode;
   logic [NCH-1:0]   pdn_pin_standby;

   dual_chan_cfg_bank #(.NCH(NCH)) i_dual_chan_cfg_bank (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr), .wdata(wdata),
      .rdata(rdata), .lsb_first(lsb_first), .clk_stab_en(clk_stab_en),
      .pwr_mode(pwr_mode), .pdn_pin_standby(pdn_pin_standby));

   always #5 clk = ~clk;

   int n_run = 0;
   int n_fail = 0;
   bit done = 1'b0;

   // behavioural reference state
   int m_pwr[NCH];
   int s_pwr[NCH];
   int m_clk, s_clk, r_lsb, r_srst, r_sel, r_xfer;

   task automatic model_defaults();
      for (int c = 0; c < NCH; c++) begin
         m_pwr[c] = 0;
         s_pwr[c] = 0;
      end
      m_clk = 1; s_clk = 1; r_lsb = 0; r_srst = 0; r_sel = (1 << NCH) - 1; r_xfer = 0;
   endtask

   function automatic int exp_read(int a);
      case (a)
         'h00: return 'h18 | (r_lsb ? 'h42 : 0) | (r_srst ? 'h24 : 0);
         'h01: return 'h88;
         'h02: return 'h50;
         'h05: return r_sel;
         'h08: begin
            for (int c = 0; c < NCH; c++) if ((r_sel >> c) & 1) return m_pwr[c];
            return 0;
         end
         'h09: return m_clk;
         'hFF: return r_xfer;
         default: return 0;
      endcase
   endfunction

   task automatic check(string tag, string what, int act, int exp);
      n_run++;
      if (act != exp) begin
         n_fail++;
         $display("FAIL %s %s: actual 0x%0h expected 0x%0h", tag, what, act, exp);
      end
   endtask

   task automatic model_update(bit we, int a, int d);
      int nx;
      if (r_srst != 0) begin
         model_defaults();
         return;
      end
      nx = (we && a == 'hFF) ? (d & 1) : 0;
      if (r_xfer != 0) begin
         for (int c = 0; c < NCH; c++) s_pwr[c] = m_pwr[c];
         s_clk = m_clk;
      end
      if (we) begin
         case (a)
            'h00: begin
               r_lsb  = ((d >> 6) | (d >> 1)) & 1;
               r_srst = ((d >> 5) | (d >> 2)) & 1;
            end
            'h05: r_sel = d & ((1 << NCH) - 1);
            'h08: for (int c = 0; c < NCH; c++) if ((r_sel >> c) & 1) m_pwr[c] = d & 'h23;
            'h09: m_clk = d & 1;
            default: ;
         endcase
      end
      r_xfer = nx;
   endtask

   // one clock: drive, compare every output against the model, then advance the model
   task automatic step(bit we, int a, int d, string tag);
      @(negedge clk);
      wr_en = we; addr = 8'(a); wdata = 8'(d);
      #4;
      check(tag, "rdata", int'(rdata), exp_read(a));
      check(tag, "lsb_first", int'(lsb_first), r_lsb);
      check(tag, "clk_stab_en", int'(clk_stab_en), s_clk);
      for (int c = 0; c < NCH; c++) begin
         check(tag, "pwr_mode", int'(pwr_mode[c*2 +: 2]), s_pwr[c] & 3);
         check(tag, "pdn_pin_standby", int'(pdn_pin_standby[c]), (s_pwr[c] >> 5) & 1);
      end
      @(posedge clk);
      model_update(we, a, d);
   endtask

   task automatic rd(int a, string tag);
      step(1'b0, a, 0, tag);
   endtask

   task automatic wr(int a, int d, string tag);
      step(1'b1, a, d, tag);
   endtask

   initial begin
      model_defaults();
      repeat (3) @(posedge clk);
      @(negedge clk);
      rst_n = 1'b1;

      // R1 reset values
      rd('h00, "R1"); rd('h05, "R1"); rd('h08, "R1"); rd('h09, "R1"); rd('hFF, "R1");
      // R4 identity
      rd('h01, "R4"); wr('h01, 'h00, "R4"); rd('h01, "R4");
      // R5 speed grade
      rd('h02, "R5"); wr('h02, 'hFF, "R5"); rd('h02, "R5");
      // R13 unmapped
      wr('h03, 'hAA, "R13"); rd('h03, "R13"); wr('h7F, 'hFF, "R13"); rd('h7F, "R13");
      rd('h0A, "R13"); rd('h09, "R13");
      // R6 channel select, upper bits dropped
      wr('h05, 'hFE, "R6"); rd('h05, "R6");
      // R7 channel B only
      wr('h08, 'h21, "R7"); rd('h08, "R7");
      wr('h05, 'h01, "R7"); rd('h08, "R7");
      // R8 lowest enabled channel, then empty mask
      wr('h08, 'h02, "R8"); wr('h05, 'h03, "R8"); rd('h08, "R8");
      wr('h05, 'h00, "R8"); rd('h08, "R8"); wr('h08, 'h23, "R8"); rd('h08, "R8");
      wr('h05, 'h02, "R8"); rd('h08, "R8");
      // R11 field masking on both channels
      wr('h05, 'h03, "R11"); wr('h08, 'hFF, "R11"); rd('h08, "R11");
      // R12 clock register masking
      wr('h09, 'hFE, "R12"); rd('h09, "R12"); wr('h09, 'hFF, "R12"); wr('h09, 'h00, "R12");
      // R9 staged values stay off the outputs
      rd('h08, "R9"); rd('h09, "R9"); rd('h00, "R9");
      // R10 transfer with bit 0 clear does nothing
      wr('hFF, 'hFE, "R10"); rd('hFF, "R10"); rd('h00, "R10");
      // R10 transfer, write in the copy cycle keeps its new value in master only
      wr('hFF, 'h01, "R10"); wr('h09, 'h01, "R10"); rd('hFF, "R10"); rd('h09, "R10");
      wr('h05, 'h01, "R10"); wr('h08, 'h12, "R10"); wr('hFF, 'h01, "R10"); rd('hFF, "R10");
      rd('h08, "R10");
      // R2 bit-order flag from either mirrored position
      wr('h00, 'h40, "R2"); rd('h00, "R2"); wr('h00, 'h00, "R2"); rd('h00, "R2");
      wr('h00, 'h02, "R2"); rd('h00, "R2");
      // R3 soft reset from a non-default state, bit 5
      wr('h05, 'h02, "R3"); wr('h08, 'h21, "R3"); wr('h09, 'h00, "R3"); wr('hFF, 'h01, "R3");
      rd('h08, "R3");
      wr('h00, 'h20, "R3"); wr('h09, 'h00, "R3");
      rd('h00, "R3"); rd('h05, "R3"); rd('h08, "R3"); rd('h09, "R3");
      // R3 soft reset through bit 2
      wr('h08, 'h03, "R3"); wr('hFF, 'h01, "R3"); rd('h00, "R3");
      wr('h00, 'h04, "R3"); rd('h00, "R3"); rd('h00, "R3"); rd('h08, "R3");

      @(negedge clk);
      wr_en = 1'b0;
      done = 1'b1;
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
   end

   initial begin
      #200000;
      if (!done) begin
         n_run++;
         n_fail++;
         $display("FAIL watchdog: actual hung expected finished");
         $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
         $finish;
      end
   end
endmodule